// File: doc/BRIEF.md
# Retired-Instruction Counter with Explicit-Access Override

This block keeps the 64-bit count of retired instructions for one hart. Each cycle in which the pipeline signals a retirement, the count advances by one. It wraps to zero past the all-ones value. Software reaches the count through a narrow CSR-style port, 32 bits wide. A half-select input picks the low or the high word. A write-enable with write data replaces the selected word.

An instruction can retire in the same cycle that it reads or writes the counter. The block settles that collision by fixed rules:

- A read returns the value the counter held before that instruction counted itself.
- A write replaces the implicit increment. The instruction that follows reads the written value, with no extra one added.

Reads are combinational from the stored count, so they always see the pre-retirement value.

Top module: `instret_counter`

## Requirements
- R1: After reset the stored count is zero, so both halves read as 0.
- R2: A cycle with the retire strobe high and write-enable low raises the 64-bit count by exactly one, with carry from the low into the high half.
- R3: A cycle with both the retire strobe and write-enable low leaves the count unchanged.
- R4: A write puts the write data into the selected half exactly. Half-select 0 is bits 31:0 and half-select 1 is bits 63:32.
- R5: A write leaves the half it does not select unchanged.
- R6: When a write and a retirement fall in the same cycle, the write wins. No increment is applied, and the next read of the written half returns the written data exactly.
- R7: The read data presented in a cycle with the retire strobe high is the count from before that retirement.
- R8: The all-ones count followed by a retirement becomes zero.
- R9: The read data shows bits 31:0 when half-select is 0 and bits 63:32 when it is 1. Reading does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retires this cycle |
| csr_we_i | input | 1 | Explicit write to the selected half |
| csr_half_i | input | 1 | Half select: 0 low word, 1 high word |
| csr_wdata_i | input | 32 | Data for an explicit write |
| csr_rdata_o | output | 32 | Selected half of the count before this cycle's update |

## Verification
The assertions check four things on every cycle:

- Increment by one on a plain retirement.
- Hold when the cycle is idle.
- Exact replacement of the written half, and preservation of the other half.
- Wrap from all-ones to zero.

Some behaviour shows only in the bench's scenarios, because it depends on what software later reads. That covers the pre-retirement value on a read that coincides with retirement, and a write winning over a same-cycle retirement when the next instruction reads back. It also covers carry across the half boundary and the reset value at the read port.

// File: rtl/instret_pkg.sv
package instret_pkg;
  localparam int unsigned INSTRET_CNT_W = 64;
  localparam int unsigned INSTRET_BUS_W = 32;

  // Source chosen for the next stored count
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_INC   = 2'd1,
    SRC_WRITE = 2'd2
  } cnt_src_e;
endpackage

// File: rtl/instret_incr.sv
module instret_incr #(
  parameter int unsigned CNT_W = 64
) (
  input  logic [CNT_W-1:0] cur_i,
  output logic [CNT_W-1:0] inc_o,
  output logic             wrap_o
);
  // Modulo-2^CNT_W step; carry out flags the wrap
  function automatic logic [CNT_W:0] step_one(input logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic [CNT_W:0] sum;
  assign sum    = step_one(cur_i);
  assign inc_o  = sum[CNT_W-1:0];
  assign wrap_o = sum[CNT_W];
endmodule

// File: rtl/instret_wr_merge.sv
module instret_wr_merge #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 1
) (
  input  logic [CNT_W-1:0]  cur_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  merged_o
);
  localparam int unsigned HALVES = CNT_W / DATA_W;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic hit;
    assign hit = we_i && (sel_i == SEL_W'(h));
    assign merged_o[h*DATA_W +: DATA_W] = hit ? wdata_i : cur_i[h*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/instret_rd_mux.sv
module instret_rd_mux #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 1
) (
  input  logic [CNT_W-1:0]  cur_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HALVES = CNT_W / DATA_W;

  logic [DATA_W-1:0] slice [HALVES];
  for (genvar h = 0; h < HALVES; h++) begin : g_slice
    assign slice[h] = cur_i[h*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata_o = '0;
    for (int unsigned i = 0; i < HALVES; i++) begin
      if (sel_i == SEL_W'(i)) rdata_o = slice[i];
    end
  end
endmodule

// File: rtl/instret_counter.sv
module instret_counter
  import instret_pkg::*;
#(
  parameter int unsigned CNT_W  = INSTRET_CNT_W,
  parameter int unsigned DATA_W = INSTRET_BUS_W,
  localparam int unsigned HALVES = CNT_W / DATA_W,
  localparam int unsigned SEL_W  = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic              csr_we_i,
  input  logic [SEL_W-1:0]  csr_half_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  output logic [DATA_W-1:0] csr_rdata_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_merged;
  logic             inc_wrap;

  // Named events for the assertions
  logic     inc_fire;
  logic     wr_fire;
  cnt_src_e src;

  assign wr_fire  = csr_we_i;
  assign inc_fire = retire_i && !csr_we_i;

  instret_incr #(.CNT_W(CNT_W)) u_incr (
    .cur_i  (cnt_q),
    .inc_o  (cnt_inc),
    .wrap_o (inc_wrap)
  );

  instret_wr_merge #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_merge (
    .cur_i    (cnt_q),
    .we_i     (csr_we_i),
    .sel_i    (csr_half_i),
    .wdata_i  (csr_wdata_i),
    .merged_o (cnt_merged)
  );

  instret_rd_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_rd (
    .cur_i   (cnt_q),
    .sel_i   (csr_half_i),
    .rdata_o (csr_rdata_o)
  );

  // Explicit write outranks the implicit increment
  always_comb begin
    if (wr_fire)       src = SRC_WRITE;
    else if (inc_fire) src = SRC_INC;
    else               src = SRC_HOLD;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (src)
        SRC_WRITE: cnt_q <= cnt_merged;
        SRC_INC:   cnt_q <= cnt_inc;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !csr_we_i) |=> (cnt_q - $past(cnt_q)) == CNT_W'(1));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !csr_we_i) |=> $stable(cnt_q));

  p_wrap_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !csr_we_i && (&cnt_q)) |=> (cnt_q == '0) && $past(inc_wrap));

  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    p_wr_exact_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_we_i && csr_half_i == SEL_W'(h)) |=>
        cnt_q[h*DATA_W +: DATA_W] == $past(csr_wdata_i));

    p_other_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_we_i && csr_half_i != SEL_W'(h)) |=>
        $stable(cnt_q[h*DATA_W +: DATA_W]));
  end
endmodule

// File: tb/instret_counter_tb.sv
module instret_counter_tb;
  localparam time TCK = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire = 1'b0;
  logic        we = 1'b0;
  logic [0:0]  half = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  always #(TCK/2) clk = ~clk;

  instret_counter u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .retire_i    (retire),
    .csr_we_i    (we),
    .csr_half_i  (half),
    .csr_wdata_i (wdata),
    .csr_rdata_o (rdata)
  );

  // Reference count kept by the bench
  logic [63:0] model = '0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  // Driver: one instruction per cycle, pushes the expected read value
  task automatic op(input bit ret, input bit w, input bit hi,
                    input logic [31:0] d, input bit chk, input string tag);
    @(negedge clk);
    retire = ret; we = w; half = hi; wdata = d;
    if (chk) begin
      exp_q.push_back(hi ? model[63:32] : model[31:0]);
      tag_q.push_back(tag);
    end
    if (w) begin
      if (hi) model[63:32] = d; else model[31:0] = d;
    end else if (ret) begin
      model = model + 64'd1;
    end
  endtask

  task automatic rd(input bit hi, input string tag);
    op(1'b0, 1'b0, hi, 32'h0, 1'b1, tag);
  endtask

  // Monitor: samples mid low phase and compares against the queue
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    // R1 reset value
    rd(1'b0, "R1 low after reset");
    rd(1'b1, "R1 high after reset");
    // R2 plain retirements
    for (int i = 0; i < 5; i++) op(1'b1, 1'b0, 1'b0, 32'h0, 1'b0, "");
    rd(1'b0, "R2 five retirements");
    // R7 read during retirement shows pre value, then the new one
    op(1'b1, 1'b0, 1'b0, 32'h0, 1'b1, "R7 read with retire");
    rd(1'b0, "R7 after retire");
    // R3 idle cycles
    for (int i = 0; i < 4; i++) op(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, "");
    rd(1'b0, "R3 idle hold");
    // R4/R5 write low without retire
    op(1'b0, 1'b1, 1'b0, 32'hFFFF_FFF0, 1'b0, "");
    rd(1'b0, "R4 low written");
    rd(1'b1, "R5 high kept");
    // R6 write with retire: no increment
    op(1'b1, 1'b1, 1'b0, 32'd100, 1'b1, "R6 read during write");
    rd(1'b0, "R6 exact written value");
    // R2 carry across halves
    op(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, "");
    op(1'b1, 1'b0, 1'b0, 32'h0, 1'b0, "");
    rd(1'b1, "R2 carry into high");
    rd(1'b0, "R2 low wrapped");
    // R5/R6 write high with retire
    op(1'b0, 1'b1, 1'b0, 32'h1234_5678, 1'b0, "");
    op(1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF, 1'b0, "");
    rd(1'b1, "R6 high exact");
    rd(1'b0, "R5 low kept");
    // R9 repeated reads do not change the count
    rd(1'b0, "R9 low repeat");
    rd(1'b1, "R9 high repeat");
    rd(1'b0, "R9 low again");
    // R8 wrap from all ones
    op(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, "");
    op(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, "");
    rd(1'b1, "R8 high all ones");
    op(1'b1, 1'b0, 1'b0, 32'h0, 1'b1, "R8 read at wrap");
    rd(1'b0, "R8 low zero");
    rd(1'b1, "R8 high zero");
    op(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, "");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule